// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block sits between instruction decode and issue. Decode hands it one scalar operation together with a vector length, a scalar-or-vector tag and a base register number for each of the destination and two sources, a predicate mask and a zeroing flag. The sequencer holds the program counter by staying busy. While busy, it plays out the operation as a series of element micro-operations, one for each element index and always in ascending order. Each micro-operation carries the three register indices to use and a command that says whether to write the computed result, write zero, or write nothing.

A vector-tagged operand steps one register further for each element. A scalar-tagged operand stays on its base register. When the destination is scalar, the loop stops right after the first element whose predicate bit is set, so the predicate picks which source element feeds the single result. Element micro-operations leave through a valid/ready handshake. A one-cycle done pulse tells the front end that the program counter may advance.

Top module: `vec_elem_seq`

## Requirements
- R1: A new operation is accepted only when `start_ready` is high, and `start_ready` is low for the whole loop. Operand inputs are sampled on acceptance, and inputs presented while busy have no effect. `done` pulses high for one cycle in the cycle after the final element handshake, and `start_ready` is high again in that cycle.
- R2: Elements are issued one per handshake, with `out_idx` counting 0, 1, 2, … in strictly ascending order.
- R3: A vector-tagged operand presents base plus element index, modulo 128. A scalar-tagged operand presents its base register for every element.
- R4: When predicate bit `out_idx` is set (mask bit i belongs to element i), the element carries `out_wr`=1 and `out_zero`=0.
- R5: When the predicate bit is clear and zeroing is off, the element is still issued, with `out_wr`=0 and `out_zero`=0. The operand indices of later elements still advance.
- R6: When the predicate bit is clear and zeroing is on, the element carries `out_zero`=1 and `out_wr`=0.
- R7: When `pred_en` is low, the mask input is ignored and every element is treated as enabled.
- R8: With a scalar destination, the loop ends after the first element whose predicate bit is set. If no bit is set within the vector length, all elements are issued.
- R9: A vector length of zero issues no element, and `done` pulses in the cycle after acceptance.
- R10: While `out_valid` is high and `out_ready` is low, every element output holds its value.
- R11: A vector length above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Decoded operation present |
| start_ready | output | 1 | Sequencer idle, operation will be taken |
| vlen | input | 7 | Vector length (values above 64 are clamped) |
| dst_vec | input | 1 | Destination is vector-tagged |
| src1_vec | input | 1 | Source 1 is vector-tagged |
| src2_vec | input | 1 | Source 2 is vector-tagged |
| dst_base | input | 7 | Destination base register |
| src1_base | input | 7 | Source 1 base register |
| src2_base | input | 7 | Source 2 base register |
| pred_en | input | 1 | Predicate mask in use |
| pred_mask | input | 64 | Per-element enable bits, bit i for element i |
| zero_mode | input | 1 | Masked-out elements write zero |
| out_valid | output | 1 | Element micro-operation present |
| out_ready | input | 1 | Downstream accepts the element |
| out_idx | output | 6 | Element index |
| out_dst | output | 7 | Destination register index |
| out_src1 | output | 7 | Source 1 register index |
| out_src2 | output | 7 | Source 2 register index |
| out_wr | output | 1 | Write the computed result |
| out_zero | output | 1 | Write zero to the destination |
| done | output | 1 | Loop finished, program counter may advance |

## Verification
A corrupted element counter shows up at once as a skipped or repeated `out_idx` and as wrong vector register indices on the next handshake. A wrong latched tag shows up as an index that stays fixed or moves when it should not. A bad end-of-loop decision shows up as an element count that differs from the model, and as `done` arriving one or more handshakes early or late. A predicate bit read at the wrong position shows up on the first element whose command differs from its neighbour. The directed cases put such a transition at a known index, and they include a stall, so that a counter that moves while stalled is also exposed.

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int MAX_VL = 64,
  parameter int REG_W  = 7,
  localparam int LEN_W = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [LEN_W-1:0]  vlen,
  input  logic              dst_vec,
  input  logic              src1_vec,
  input  logic              src2_vec,
  input  logic [REG_W-1:0]  dst_base,
  input  logic [REG_W-1:0]  src1_base,
  input  logic [REG_W-1:0]  src2_base,
  input  logic              pred_en,
  input  logic [MAX_VL-1:0] pred_mask,
  input  logic              zero_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_idx,
  output logic [REG_W-1:0]  out_dst,
  output logic [REG_W-1:0]  out_src1,
  output logic [REG_W-1:0]  out_src2,
  output logic              out_wr,
  output logic              out_zero,
  output logic              done
);

  logic              busy_q, done_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  vl_q;
  logic              dst_vec_q, src1_vec_q, src2_vec_q;
  logic [REG_W-1:0]  dst_base_q, src1_base_q, src2_base_q;
  logic              pen_q, zm_q;
  logic [MAX_VL-1:0] mask_q;

  logic [LEN_W-1:0]  vl_clamp;
  logic              take, fire, pbit, is_last, finish;
  logic [REG_W-1:0]  step;

  assign vl_clamp = (vlen > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : vlen;
  assign take     = start_valid && !busy_q;
  assign fire     = busy_q && out_ready;
  assign pbit     = pen_q ? mask_q[idx_q] : 1'b1;
  assign is_last  = (LEN_W'(idx_q) + LEN_W'(1)) == vl_q;
  assign finish   = fire && (is_last || (!dst_vec_q && pbit));
  assign step     = REG_W'(idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      idx_q       <= '0;
      vl_q        <= '0;
      dst_vec_q   <= 1'b0;
      src1_vec_q  <= 1'b0;
      src2_vec_q  <= 1'b0;
      dst_base_q  <= '0;
      src1_base_q <= '0;
      src2_base_q <= '0;
      pen_q       <= 1'b0;
      zm_q        <= 1'b0;
      mask_q      <= '0;
    end else begin
      done_q <= (take && vl_clamp == '0) || finish;
      if (take) begin
        busy_q      <= (vl_clamp != '0);
        idx_q       <= '0;
        vl_q        <= vl_clamp;
        dst_vec_q   <= dst_vec;
        src1_vec_q  <= src1_vec;
        src2_vec_q  <= src2_vec;
        dst_base_q  <= dst_base;
        src1_base_q <= src1_base;
        src2_base_q <= src2_base;
        pen_q       <= pred_en;
        zm_q        <= zero_mode;
        mask_q      <= pred_mask;
      end else if (finish) begin
        busy_q <= 1'b0;
      end else if (fire) begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign start_ready = !busy_q;
  assign out_valid   = busy_q;
  assign out_idx     = idx_q;
  assign out_dst     = dst_base_q  + (dst_vec_q  ? step : '0);
  assign out_src1    = src1_base_q + (src1_vec_q ? step : '0);
  assign out_src2    = src2_base_q + (src2_vec_q ? step : '0);
  assign out_wr      = pbit;
  assign out_zero    = !pbit && zm_q;
  assign done        = done_q;

endmodule

// File: rtl/vec_elem_seq_chk.sv
module vec_elem_seq_chk #(
  parameter int IDX_W = 6,
  parameter int REG_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] out_idx,
  input logic [REG_W-1:0] out_dst,
  input logic [REG_W-1:0] out_src1,
  input logic [REG_W-1:0] out_src2,
  input logic             out_wr,
  input logic             out_zero,
  input logic             done,
  input logic             start_ready,
  input logic             dst_vec_q
);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_idx) && $stable(out_dst)
      && $stable(out_src1) && $stable(out_src2) && $stable(out_wr) && $stable(out_zero));

  p_cmd_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_wr && out_zero));

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid || out_idx == IDX_W'($past(out_idx) + 1'b1));

  p_first_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_idx == '0);

  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid && start_ready);

  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !start_ready);

  p_scalar_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !dst_vec_q && out_wr |=> !out_valid && done);

endmodule

bind vec_elem_seq vec_elem_seq_chk #(.IDX_W(IDX_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_idx(out_idx), .out_dst(out_dst), .out_src1(out_src1), .out_src2(out_src2),
  .out_wr(out_wr), .out_zero(out_zero), .done(done), .start_ready(start_ready),
  .dst_vec_q(dst_vec_q)
);

// File: tb/vec_elem_seq_tb.sv
`timescale 1ns/1ps
module vec_elem_seq_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        start_valid = 0, start_ready;
  logic [6:0]  vlen = 0;
  logic        dst_vec = 0, src1_vec = 0, src2_vec = 0;
  logic [6:0]  dst_base = 0, src1_base = 0, src2_base = 0;
  logic        pred_en = 0, zero_mode = 0;
  logic [63:0] pred_mask = 0;
  logic        out_valid, out_ready = 1;
  logic [5:0]  out_idx;
  logic [6:0]  out_dst, out_src1, out_src2;
  logic        out_wr, out_zero, done;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  vec_elem_seq dut_i (.*);

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(string req, int vl, bit dv, bit s1v, bit s2v,
                        logic [6:0] db, logic [6:0] s1b, logic [6:0] s2b,
                        bit pen, logic [63:0] mask, bit zm, bit stall, bit poke);
    int vle, n_exp, got;
    bit seen_done, have_hold;
    logic [28:0] held;
    vle = (vl > 64) ? 64 : vl;
    n_exp = 0;
    for (int i = 0; i < vle; i++) begin
      n_exp++;
      if (!dv && (!pen || mask[i])) break;
    end
    @(negedge clk);
    chk(start_ready == 1'b1, "R1", {req, " idle before start"}, start_ready, 1);
    start_valid = 1; vlen = 7'(vl); dst_vec = dv; src1_vec = s1v; src2_vec = s2v;
    dst_base = db; src1_base = s1b; src2_base = s2b;
    pred_en = pen; pred_mask = mask; zero_mode = zm;
    @(negedge clk);
    start_valid = 0;
    got = 0; seen_done = 0; have_hold = 0; held = '0;
    for (int cyc = 0; cyc < 400 && !seen_done; cyc++) begin
      bit rdy;
      if (cyc > 0) @(negedge clk);
      if (have_hold) begin
        chk(out_valid && {out_idx, out_dst, out_src1, out_src2, out_wr, out_zero} == held,
            "R10", {req, " hold under stall"},
            {out_idx, out_dst, out_src1, out_src2, out_wr, out_zero}, held);
        have_hold = 0;
      end
      if (poke) begin
        if (cyc == 0) begin
          start_valid = 1; vlen = 7'd3; dst_base = 7'h55; dst_vec = ~dv; pred_mask = '0;
          chk(start_ready == 1'b0, "R1", {req, " busy refuses start"}, start_ready, 0);
        end else if (cyc == 1) start_valid = 0;
      end
      if (done) begin
        seen_done = 1;
      end else begin
        rdy = !(stall && (cyc % 3 == 1));
        out_ready = rdy;
        if (out_valid) begin
          if (rdy) begin
            logic [28:0] exp;
            bit b;
            b = !pen || mask[got];
            exp = {6'(got), 7'(db + (dv ? got : 0)), 7'(s1b + (s1v ? got : 0)),
                   7'(s2b + (s2v ? got : 0)), b, !b && zm};
            chk({out_idx, out_dst, out_src1, out_src2, out_wr, out_zero} == exp, req,
                $sformatf("element %0d", got),
                {out_idx, out_dst, out_src1, out_src2, out_wr, out_zero}, exp);
            got++;
          end else begin
            held = {out_idx, out_dst, out_src1, out_src2, out_wr, out_zero};
            have_hold = 1;
          end
        end
      end
    end
    out_ready = 1;
    chk(seen_done, "R1", {req, " done pulse seen"}, seen_done, 1);
    chk(got == n_exp, req, "element count", got, n_exp);
    chk(start_ready == 1'b1 && out_valid == 1'b0, "R1", {req, " idle with done"},
        {start_ready, out_valid}, 2'b10);
    @(negedge clk);
    chk(done == 1'b0, "R1", {req, " done is one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 0 && done == 0 && start_ready == 1, "R1", "reset state",
        {out_valid, done, start_ready}, 3'b001);
  endtask

  task automatic t_all_vector();   // R2 R3 R4
    run_op("R2", 5, 1, 1, 1, 7'd8, 7'd20, 7'd40, 0, '0, 0, 0, 0);
  endtask

  task automatic t_mixed_wrap();   // R3: scalar src1, vector wrap past 127
    run_op("R3", 6, 1, 0, 1, 7'd125, 7'd3, 7'd126, 1, 64'hFF, 0, 0, 0);
  endtask

  task automatic t_pred_skip();    // R5
    run_op("R5", 8, 1, 1, 0, 7'd16, 7'd32, 7'd2, 1, 64'b1010_0110, 0, 0, 0);
  endtask

  task automatic t_zeroing();      // R6 with R4
    run_op("R6", 8, 1, 1, 1, 7'd0, 7'd64, 7'd96, 1, 64'b0110_1001, 1, 0, 0);
  endtask

  task automatic t_no_pred();      // R7: mask zero but ignored
    run_op("R7", 4, 1, 1, 1, 7'd10, 7'd11, 7'd12, 0, 64'h0, 1, 0, 0);
  endtask

  task automatic t_scalar_select(); // R8: first set bit at 3
    run_op("R8", 10, 0, 1, 1, 7'd5, 7'd50, 7'd70, 1, 64'b1_1000, 1, 0, 0);
  endtask

  task automatic t_scalar_none();  // R8: no set bit, all elements
    run_op("R8", 6, 0, 1, 0, 7'd5, 7'd50, 7'd70, 1, 64'h0, 1, 0, 0);
  endtask

  task automatic t_vl_zero();      // R9
    run_op("R9", 0, 1, 1, 1, 7'd1, 7'd2, 7'd3, 0, '0, 0, 0, 0);
  endtask

  task automatic t_stall();        // R10
    run_op("R10", 9, 1, 0, 1, 7'd30, 7'd31, 7'd60, 1, 64'b1_0101_0101, 1, 1, 0);
  endtask

  task automatic t_vl_clamp();     // R11
    run_op("R11", 100, 1, 1, 1, 7'd0, 7'd64, 7'd0, 1, 64'h8000_0000_0000_0001, 0, 0, 0);
  endtask

  task automatic t_busy_ignore();  // R1
    run_op("R1", 6, 1, 1, 1, 7'd40, 7'd41, 7'd42, 0, '0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_all_vector();
    t_mixed_wrap();
    t_pred_skip();
    t_zeroing();
    t_no_pred();
    t_scalar_select();
    t_scalar_none();
    t_vl_zero();
    t_stall();
    t_vl_clamp();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule